// File: doc/BRIEF.md
# Blocking Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a slower main memory. It keeps 1024 lines of four 32-bit words each (16 KB), placed by direct mapping: the line slot is the block address modulo the number of lines. Every line carries a stored tag, a valid flag and a dirty flag. A small controller takes one request at a time. It compares the stored tag with the request tag. On a hit it returns or replaces one word. On a miss it first writes a modified victim line back to memory, then reads the whole new line, installs it, and re-runs the lookup to finish the original access.

The processor side is a valid/ready pair. A request is offered by raising `cpu_valid` with `cpu_we`, `cpu_addr` and `cpu_wdata`. These must stay stable until `cpu_ready` is seen high. `cpu_ready` is the back-pressure: it stays low while the access is in progress and is high for exactly one cycle per request. The memory side is also valid/ready. The block holds `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stable until memory answers with `mem_ready`. A read transfer takes its line from `mem_rdata` in the cycle where `mem_ready` is high. Transfers always move one complete 128-bit line.

Top module: `dm_wb_cache`

## Requirements
- R1: The byte address is split into tag = bits [31:14], line index = bits [13:4] and word select = bits [3:2]. Bits [1:0] have no effect on which word is read or written. Every memory transfer address has bits [3:0] = 0 and carries the request's index in bits [13:4].
- R2: After reset, `cpu_ready` and `mem_valid` are low and every line is invalid, so the first access to any line is a miss.
- R3: A read hit returns the word chosen by bits [3:2]. `cpu_ready` is high in the cycle after the edge that first samples `cpu_valid` (one cycle), and no memory transfer takes place.
- R4: A write hit replaces only the selected word of the line and marks the line dirty. It uses the one-cycle hit timing and makes no memory transfer.
- R5: A miss on an invalid or clean line makes exactly one memory read at the line-aligned request address. Memory word k occupies `mem_rdata` bits [32k+31:32k]. The line is installed valid and clean, and the access then finishes with a hit.
- R6: A miss on a valid dirty line first writes the victim's full current contents to address {stored tag, index, 4'b0}, and only after that reads the new line.
- R7: A write miss allocates: the line is fetched, then the selected word is merged, and the line ends up dirty.
- R8: Once `mem_valid` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ready` is high.
- R9: `cpu_ready` is never high while a memory transfer is open. It stays low when no request is offered, and it drops the cycle after it was high.
- R10: On a miss, `cpu_ready` rises in the cycle after the edge that accepts the last memory handshake of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request offered |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while cpu_ready is high |
| cpu_ready | output | 1 | Request complete (one cycle) |
| mem_valid | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Line being read |
| mem_ready | input | 1 | Memory completes the transfer |

## Verification
Timing is counted from the first clock edge that sees `cpu_valid`. A hit completes one cycle later. With a memory that answers L cycles after a transfer opens, a clean or invalid miss completes after 2+L cycles, and a dirty miss completes after 3+2L cycles, because the write-back and the refill each cost one handshake. The bench memory answers after a fixed delay, and the bench predicts hit, clean miss or dirty miss from its own model of tags and flags. It counts edges until `cpu_ready` and requires the exact figure. It reads outputs only at falling edges. Each memory transfer is checked at the cycle where it is accepted: its address, its direction and, for write-backs, the line contents.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL
  } ctrl_state_e;
endpackage

// File: rtl/cache_tags.sv
module cache_tags #(
  parameter int LINES = 1024,
  parameter int IDX_W = 10,
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (dirty_set) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  // a line can only be dirty while it is valid
  assert_dirty_implies_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dirty |-> rd_valid);
endmodule

// File: rtl/cache_lines.sv
module cache_lines #(
  parameter int LINES      = 1024,
  parameter int IDX_W      = 10,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SEL_W      = 2,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              word_wr,
  input  logic [SEL_W-1:0]  word_sel,
  input  logic [WORD_W-1:0] word_data,
  output logic [LINE_W-1:0] line_out,
  output logic [WORD_W-1:0] word_out
);
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] lane_q [LINES];
    always_ff @(posedge clk) begin
      if (fill_en)
        lane_q[idx] <= fill_line[w*WORD_W +: WORD_W];
      else if (word_wr && word_sel == SEL_W'(w))
        lane_q[idx] <= word_data;
    end
    assign line_out[w*WORD_W +: WORD_W] = lane_q[idx];
  end

  assign word_out = line_out[WORD_W*int'(word_sel) +: WORD_W];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 18,
  parameter int OFF_W  = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic              look_valid,
  input  logic              look_dirty,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic              mem_ready,
  output logic              cpu_ready,
  output logic [IDX_W-1:0]  req_idx,
  output logic [TAG_W-1:0]  req_tag,
  output logic [SEL_W-1:0]  req_sel,
  output logic              req_we,
  output logic [WORD_W-1:0] req_wdata,
  output logic              word_wr,
  output logic              fill_en,
  output logic              mem_valid,
  output logic              mem_we
);
  localparam int BYTE_W = OFF_W - SEL_W;

  ctrl_state_e state_q, state_d;
  logic        hit;
  logic [BYTE_W-1:0] unused_byte_bits;

  assign unused_byte_bits = cpu_addr[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_idx   <= '0;
      req_tag   <= '0;
      req_sel   <= '0;
      req_we    <= 1'b0;
      req_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_valid) begin
        req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
        req_idx   <= cpu_addr[OFF_W +: IDX_W];
        req_sel   <= cpu_addr[BYTE_W +: SEL_W];
        req_we    <= cpu_we;
        req_wdata <= cpu_wdata;
      end
    end
  end

  assign hit = look_valid && (look_tag == req_tag);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cpu_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit)                          state_d = ST_IDLE;
        else if (look_valid && look_dirty) state_d = ST_EVICT;
        else                              state_d = ST_FILL;
      end
      ST_EVICT:  if (mem_ready) state_d = ST_FILL;
      ST_FILL:   if (mem_ready) state_d = ST_LOOKUP;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign cpu_ready = (state_q == ST_LOOKUP) && hit;
  assign word_wr   = cpu_ready && req_we;
  assign mem_valid = (state_q == ST_EVICT) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_EVICT);
  assign fill_en   = (state_q == ST_FILL) && mem_ready;

  // a completed refill makes the re-run lookup hit
  assert_fill_then_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FILL) && mem_ready) |=> hit);
  // a write-back handshake is always followed by a line read
  assert_evict_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_ready) |=> (mem_valid && !mem_we));
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 1024,
  localparam int LINE_W    = WORD_W * LINE_WORDS,
  localparam int OFF_W     = $clog2(LINE_W / 8),
  localparam int SEL_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [SEL_W-1:0]  req_sel;
  logic              req_we;
  logic [WORD_W-1:0] req_wdata;
  logic              look_valid, look_dirty;
  logic [TAG_W-1:0]  look_tag;
  logic              word_wr, fill_en;

  cache_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .IDX_W(IDX_W),
    .TAG_W(TAG_W), .OFF_W(OFF_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk, .rst_n, .cpu_valid, .cpu_we, .cpu_addr, .cpu_wdata,
    .look_valid, .look_dirty, .look_tag, .mem_ready,
    .cpu_ready, .req_idx, .req_tag, .req_sel, .req_we, .req_wdata,
    .word_wr, .fill_en, .mem_valid, .mem_we
  );

  cache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .idx(req_idx), .fill_en, .fill_tag(req_tag),
    .dirty_set(word_wr), .rd_valid(look_valid), .rd_dirty(look_dirty),
    .rd_tag(look_tag)
  );

  cache_lines #(
    .LINES(LINES), .IDX_W(IDX_W), .WORD_W(WORD_W),
    .LINE_WORDS(LINE_WORDS), .SEL_W(SEL_W)
  ) u_lines (
    .clk, .idx(req_idx), .fill_en, .fill_line(mem_rdata),
    .word_wr, .word_sel(req_sel), .word_data(req_wdata),
    .line_out(mem_wdata), .word_out(cpu_rdata)
  );

  // victim address uses the stored tag, refill uses the request tag
  assign mem_addr = {(mem_we ? look_tag : req_tag), req_idx, {OFF_W{1'b0}}};

  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_no_ready_in_transfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_valid);
  assert_ready_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0 && mem_addr[OFF_W +: IDX_W] == req_idx));
  assert_victim_differs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr[ADDR_W-1 -: TAG_W] != req_tag));
  assert_write_marks_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && req_we) |=> look_dirty);
endmodule

// File: tb/dm_wb_cache_test.sv
module dm_wb_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cpu_valid, cpu_we;
  logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic         mem_ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_wb_cache uut (
    .clk, .rst_n, .cpu_valid, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata,
    .cpu_ready, .mem_valid, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ready
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------- reference contents ----------
  logic [127:0] mem_store [int unsigned];
  logic [31:0]  ref_words [int unsigned];
  bit [17:0]    m_tag   [int];
  bit           m_valid [int];
  bit           m_dirty [int];

  function automatic logic [31:0] seed_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A51E0F;
  endfunction

  function automatic logic [127:0] mem_line(input logic [31:0] la);
    logic [127:0] l;
    if (mem_store.exists(la)) return mem_store[la];
    for (int k = 0; k < 4; k++) l[32*k +: 32] = seed_word({la[27:0], 4'b0} + 32'(4*k));
    return l;
  endfunction

  function automatic logic [31:0] ref_get(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b0};
    if (ref_words.exists(w)) return ref_words[w];
    return seed_word(w);
  endfunction

  function automatic logic [127:0] ref_line(input logic [31:0] base);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[32*k +: 32] = ref_get(base + 32'(4*k));
    return l;
  endfunction

  // ---------- memory model ----------
  int          wb_cnt, rd_cnt, lat_cnt;
  logic [31:0] exp_wb_addr, exp_rd_addr, open_addr;
  string       cur_req;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      lat_cnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      lat_cnt = 0;
    end else if (mem_valid) begin
      if (lat_cnt == 0) open_addr = mem_addr;
      lat_cnt++;
      if (lat_cnt == MEM_LAT) begin
        mem_ready = 1'b1;
        check(mem_addr == open_addr, "R8", "address held", mem_addr, open_addr);
        if (mem_we) begin
          wb_cnt++;
          check(mem_addr == exp_wb_addr, "R6", "victim address", mem_addr, exp_wb_addr);
          check(mem_wdata == ref_line(exp_wb_addr), "R6", "victim line",
                mem_wdata, ref_line(exp_wb_addr));
          mem_store[mem_addr >> 4] = mem_wdata;
        end else begin
          rd_cnt++;
          check(mem_addr == exp_rd_addr, "R5", "refill address", mem_addr, exp_rd_addr);
          mem_rdata = mem_line(mem_addr >> 4);
        end
      end
    end
  end

  // ---------- one processor access ----------
  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd);
    int idx, n;
    bit [17:0] tag;
    bit hit, dirty, done;
    int exp_lat;
    string req;
    idx = int'(addr[13:4]);
    tag = addr[31:14];
    hit   = m_valid.exists(idx) && m_valid[idx] && m_tag[idx] == tag;
    dirty = !hit && m_valid.exists(idx) && m_valid[idx] && m_dirty[idx];
    exp_wb_addr = dirty ? {m_tag[idx], addr[13:4], 4'b0} : 32'h0;
    exp_rd_addr = {addr[31:4], 4'b0};
    exp_lat = hit ? 1 : (dirty ? 3 + 2*MEM_LAT : 2 + MEM_LAT);
    req = hit ? (we ? "R4" : "R3") : (dirty ? "R6" : (we ? "R7" : "R5"));
    wb_cnt = 0;
    rd_cnt = 0;
    @(negedge clk);
    check(cpu_ready == 1'b0, "R9", "ready low before request", cpu_ready, 0);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    n = 0; done = 0;
    while (!done && n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (cpu_ready) done = 1;
    end
    check(n == exp_lat, hit ? req : "R10", "cycles to ready", 128'(n), 128'(exp_lat));
    if (!we) check(cpu_rdata == ref_get(addr), req, "read word", cpu_rdata, ref_get(addr));
    check(wb_cnt == (dirty ? 1 : 0), req, "write-back count", 128'(wb_cnt), 128'(dirty));
    check(rd_cnt == (hit ? 0 : 1), req, "refill count", 128'(rd_cnt), 128'(!hit));
    cpu_valid = 1'b0;
    if (!hit) begin
      m_tag[idx] = tag; m_valid[idx] = 1'b1; m_dirty[idx] = 1'b0;
    end
    if (we) begin
      m_dirty[idx] = 1'b1;
      ref_words[{addr[31:2], 2'b0}] = wd;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] tags [4];
    void'($urandom(32'd4242));
    tags[0] = 18'h0; tags[1] = 18'h1; tags[2] = 18'h3FFFF; tags[3] = 18'h155;
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    check(cpu_ready == 1'b0, "R2", "ready in reset", cpu_ready, 0);
    check(mem_valid == 1'b0, "R2", "mem_valid in reset", mem_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cpu_ready == 1'b0 && mem_valid == 1'b0, "R9", "idle without request",
          {cpu_ready, mem_valid}, 0);
    // R2/R5: first access misses on a clean line
    access(0, 32'h0000_0040, 0);
    access(0, 32'h0000_0044, 0);                 // R3 hit, word 1
    access(1, 32'h0000_0048, 32'hDEAD_BEEF);     // R4 write hit
    access(0, 32'h0000_0048, 0);                 // R4 readback
    access(0, 32'h0000_004C, 0);                 // R4 neighbour untouched
    access(0, 32'h0001_0040, 0);                 // R6 dirty victim written back
    access(0, 32'h0000_004B, 0);                 // R1 byte bits ignored, data came back
    access(1, 32'hFFFF_FFF5, 32'h1234_5678);     // R7 write miss, index 1023
    access(0, 32'hFFFF_FFF4, 0);                 // R7 merged word
    access(0, 32'hFFFF_FFF0, 0);                 // R7 rest of refilled line
    access(1, 32'h0000_3FF0, 32'hA5A5_0001);     // R6 victim tag all ones
    access(0, 32'h0000_0000, 0);                 // R5 index 0
    // random mix over conflicting tags and a few indexes
    for (int i = 0; i < 600; i++) begin
      logic [9:0] ix;
      logic [31:0] a;
      ix = ($urandom % 2 == 0) ? 10'($urandom % 4) : 10'(1020 + $urandom % 4);
      a = {tags[$urandom % 4], ix, 2'($urandom % 4), 2'($urandom % 4)};
      access(1'($urandom % 2), a, $urandom);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule